// File: doc/BRIEF.md
# Stack Pointer and Subroutine Call Unit

This block owns the stack pointer (SP) and the program counter (PC) of a 16-bit core. Both registers sit outside the general register bank, and only the operations of this unit change them. The unit carries out push, pop, subroutine call, subroutine return, immediate add and subtract on SP, and stack-frame address generation. Push, pop, call and return each make exactly one word access on the shared SRAM port. The data that a pop reads is handed back for write-back into the general register bank.

The stack grows toward lower addresses and SP holds a byte address that moves in steps of two. A call saves the address of the following instruction (PC plus one, since PC counts words) on the memory stack, because the core has no link register. A return reloads PC directly from the stack. While a memory access is outstanding the unit raises `busy`. The issuing pipeline must hold back the next operation, and the unit ignores any operation offered in that time.

The sequencer has three states. `S_IDLE` accepts operations. `S_STORE` holds a write request for push and call. `S_LOAD` holds a read request for pop and return. The transitions are:
- T_ISSUE_STORE: `S_IDLE` to `S_STORE` on an accepted push or call.
- T_ISSUE_LOAD: `S_IDLE` to `S_LOAD` on an accepted pop or return.
- T_WAIT: stay in `S_STORE` or `S_LOAD` while `mem_ack` is low.
- T_COMPLETE: go back to `S_IDLE` on `mem_ack`, and commit SP, PC and the pop data on the same edge.

Register-only operations finish in the cycle they are accepted and keep the sequencer in `S_IDLE`.

Top module: `stack_call_unit`

## Requirements
- R1: After reset, `pc_value` and `sp_value` are 0x0000, and `busy`, `mem_req`, `pop_valid` and `frame_valid` are low.
- R2: Push (`op_kind` 3'd1) makes one write request of `op_data` to address SP-2, modulo 2^16. When it completes, SP becomes SP-2, so a push from SP 0x0000 writes at 0xFFFE.
- R3: Pop (`op_kind` 3'd2) makes one read request at SP. When it completes, SP becomes SP+2, `pop_data` holds the word read, and `pop_valid` is high for exactly one cycle.
- R4: Call (`op_kind` 3'd3) writes PC+1 to address SP-2. When it completes, SP becomes SP-2 and PC becomes `op_data`.
- R5: Return (`op_kind` 3'd4) reads the word at SP into PC. When it completes, SP becomes SP+2.
- R6: SP add (`op_kind` 3'd5) and SP subtract (`op_kind` 3'd6) change SP by the zero-extended `op_imm`, modulo 2^16. The change shows one cycle after acceptance, with no memory request.
- R7: Frame address (`op_kind` 3'd7) loads `frame_addr` with SP plus the zero-extended `op_imm` and pulses `frame_valid` for one cycle. SP and PC do not change.
- R8: Advance (`op_kind` 3'd0) increments PC by one and leaves SP unchanged.
- R9: `busy` is high from the cycle after a memory operation is accepted until its completing edge. While `mem_ack` is low, the request, its address and its write flag stay stable, and SP and PC do not change.
- R10: An operation offered while `busy` is high has no effect on SP, PC or the memory port.
- R11: Each memory operation produces exactly one acknowledged access, and `mem_req` falls on the edge that completes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_kind | input | 3 | Operation code (see requirements) |
| op_data | input | 16 | Push data or call target |
| op_imm | input | 8 | Unsigned immediate for SP add/subtract and frame offset |
| busy | output | 1 | Memory operation in progress; new operations are ignored |
| sp_value | output | 16 | Current stack pointer |
| pc_value | output | 16 | Current program counter (word address) |
| pop_valid | output | 1 | One-cycle strobe: pop data ready |
| pop_data | output | 16 | Word read by the latest pop |
| frame_valid | output | 1 | One-cycle strobe: frame address ready |
| frame_addr | output | 16 | SP plus frame offset |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address of the word accessed |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request accepted and completed this cycle |

## Verification
On every cycle the assertions check the address rules of the memory port: writes go to SP-2 and reads to SP. They also check the two-byte SP step on each completed access, that a request stays stable while it waits, that only one access is made per operation, and that there is no request outside `busy`. Only the bench's scenarios can show the values that move between memory and the registers. These are the return address saved by a call and reloaded by a return, pop data in last-in first-out order, zero extension of the immediate, and wrap-around at 0x0000 and 0xFFFE. The bench also shows that an operation offered during a stalled access is dropped.

// File: rtl/scu_pkg.sv
package scu_pkg;

    // Operation codes presented on op_kind
    typedef enum logic [2:0] {
        OP_ADVANCE = 3'd0,
        OP_PUSH    = 3'd1,
        OP_POP     = 3'd2,
        OP_CALL    = 3'd3,
        OP_RET     = 3'd4,
        OP_SPADD   = 3'd5,
        OP_SPSUB   = 3'd6,
        OP_FRAME   = 3'd7
    } scu_op_e;

    // Sequencer states
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_STORE = 2'd1,
        S_LOAD  = 2'd2
    } scu_state_e;

    function automatic logic op_is_store(scu_op_e k);
        return (k == OP_PUSH) || (k == OP_CALL);
    endfunction

    function automatic logic op_is_load(scu_op_e k);
        return (k == OP_POP) || (k == OP_RET);
    endfunction

endpackage

// File: rtl/scu_addr_gen.sv
module scu_addr_gen #(
    parameter int W     = 16,
    parameter int IMM_W = 8,
    parameter int STEP  = 2
) (
    input  logic [W-1:0]     sp,
    input  logic [W-1:0]     pc,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     sp_down,
    output logic [W-1:0]     sp_up,
    output logic [W-1:0]     sp_plus_imm,
    output logic [W-1:0]     sp_minus_imm,
    output logic [W-1:0]     pc_next
);
    localparam int PAD = W - IMM_W;

    logic [W-1:0] imm_ext;

    // Immediates are unsigned: zero-extend to the register width
    generate
        if (PAD > 0) begin : g_pad
            assign imm_ext = {{PAD{1'b0}}, imm};
        end else begin : g_nopad
            assign imm_ext = imm[W-1:0];
        end
    endgenerate

    always_comb begin
        sp_down      = sp - W'(STEP);
        sp_up        = sp + W'(STEP);
        sp_plus_imm  = sp + imm_ext;
        sp_minus_imm = sp - imm_ext;
        pc_next      = pc + W'(1);
    end
endmodule

// File: rtl/scu_seq.sv
module scu_seq
    import scu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  scu_op_e    op_kind,
    input  logic       mem_ack,
    output logic       accept,
    output logic       finish,
    output logic       busy,
    output logic       mem_req,
    output logic       mem_we,
    output scu_op_e    kind_q
);
    scu_state_e state, nxt;

    // State register and latched operation kind
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            kind_q <= OP_ADVANCE;
        end else begin
            state <= nxt;
            if (accept) begin
                kind_q <= op_kind;
            end
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (op_valid && op_is_store(op_kind)) begin
                    nxt = S_STORE;              // T_ISSUE_STORE
                end else if (op_valid && op_is_load(op_kind)) begin
                    nxt = S_LOAD;               // T_ISSUE_LOAD
                end
            end
            S_STORE, S_LOAD: begin
                if (mem_ack) begin
                    nxt = S_IDLE;               // T_COMPLETE
                end                             // else T_WAIT
            end
            default: nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept  = 1'b0;
        finish  = 1'b0;
        busy    = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (state)
            S_IDLE: begin
                accept = op_valid;
            end
            S_STORE: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                mem_we  = 1'b1;
                finish  = mem_ack;
            end
            S_LOAD: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                finish  = mem_ack;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/scu_regs.sv
module scu_regs
    import scu_pkg::*;
#(
    parameter int          W      = 16,
    parameter logic [W-1:0] SP_RST = '0,
    parameter logic [W-1:0] PC_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  scu_op_e      op_kind,
    input  logic [W-1:0] op_data,
    input  logic         finish,
    input  scu_op_e      kind_q,
    input  logic [W-1:0] mem_rdata,
    input  logic [W-1:0] sp_down,
    input  logic [W-1:0] sp_up,
    input  logic [W-1:0] sp_plus_imm,
    input  logic [W-1:0] sp_minus_imm,
    input  logic [W-1:0] pc_next,
    output logic [W-1:0] sp,
    output logic [W-1:0] pc,
    output logic [W-1:0] req_addr,
    output logic [W-1:0] req_wdata,
    output logic [W-1:0] pop_data,
    output logic         pop_valid,
    output logic [W-1:0] frame_addr,
    output logic         frame_valid
);
    logic [W-1:0] target_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp          <= SP_RST;
            pc          <= PC_RST;
            req_addr    <= '0;
            req_wdata   <= '0;
            target_q    <= '0;
            pop_data    <= '0;
            pop_valid   <= 1'b0;
            frame_addr  <= '0;
            frame_valid <= 1'b0;
        end else begin
            pop_valid   <= 1'b0;
            frame_valid <= 1'b0;

            // Issue phase: register-only operations finish here
            if (accept) begin
                unique case (op_kind)
                    OP_ADVANCE: pc <= pc_next;
                    OP_PUSH: begin
                        req_addr  <= sp_down;
                        req_wdata <= op_data;
                    end
                    OP_CALL: begin
                        req_addr  <= sp_down;
                        req_wdata <= pc_next;
                        target_q  <= op_data;
                    end
                    OP_POP, OP_RET: req_addr <= sp;
                    OP_SPADD: sp <= sp_plus_imm;
                    OP_SPSUB: sp <= sp_minus_imm;
                    OP_FRAME: begin
                        frame_addr  <= sp_plus_imm;
                        frame_valid <= 1'b1;
                    end
                    default: ;
                endcase
            end

            // Completion phase: commit SP/PC after the memory access
            if (finish) begin
                unique case (kind_q)
                    OP_PUSH: sp <= req_addr;
                    OP_CALL: begin
                        sp <= req_addr;
                        pc <= target_q;
                    end
                    OP_POP: begin
                        sp        <= sp_up;
                        pop_data  <= mem_rdata;
                        pop_valid <= 1'b1;
                    end
                    OP_RET: begin
                        sp <= sp_up;
                        pc <= mem_rdata;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit
    import scu_pkg::*;
#(
    parameter int W       = 16,
    parameter int IMM_W   = 8,
    parameter int SP_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_kind,
    input  logic [W-1:0]     op_data,
    input  logic [IMM_W-1:0] op_imm,
    output logic             busy,
    output logic [W-1:0]     sp_value,
    output logic [W-1:0]     pc_value,
    output logic             pop_valid,
    output logic [W-1:0]     pop_data,
    output logic             frame_valid,
    output logic [W-1:0]     frame_addr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    input  logic [W-1:0]     mem_rdata,
    input  logic             mem_ack
);
    scu_op_e      kind_e;
    scu_op_e      kind_q;
    logic         accept;
    logic         finish;
    logic [W-1:0] sp_down, sp_up, sp_plus_imm, sp_minus_imm, pc_next;

    assign kind_e = scu_op_e'(op_kind);

    scu_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_kind  (kind_e),
        .mem_ack  (mem_ack),
        .accept   (accept),
        .finish   (finish),
        .busy     (busy),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .kind_q   (kind_q)
    );

    scu_addr_gen #(.W(W), .IMM_W(IMM_W), .STEP(SP_STEP)) u_addr (
        .sp           (sp_value),
        .pc           (pc_value),
        .imm          (op_imm),
        .sp_down      (sp_down),
        .sp_up        (sp_up),
        .sp_plus_imm  (sp_plus_imm),
        .sp_minus_imm (sp_minus_imm),
        .pc_next      (pc_next)
    );

    scu_regs #(.W(W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .op_kind      (kind_e),
        .op_data      (op_data),
        .finish       (finish),
        .kind_q       (kind_q),
        .mem_rdata    (mem_rdata),
        .sp_down      (sp_down),
        .sp_up        (sp_up),
        .sp_plus_imm  (sp_plus_imm),
        .sp_minus_imm (sp_minus_imm),
        .pc_next      (pc_next),
        .sp           (sp_value),
        .pc           (pc_value),
        .req_addr     (mem_addr),
        .req_wdata    (mem_wdata),
        .pop_data     (pop_data),
        .pop_valid    (pop_valid),
        .frame_addr   (frame_addr),
        .frame_valid  (frame_valid)
    );
endmodule

// File: rtl/scu_chk.sv
module scu_chk #(
    parameter int W    = 16,
    parameter int STEP = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic [W-1:0] sp_value,
    input logic [W-1:0] pc_value,
    input logic         mem_req,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic         mem_ack
);
    AST_WRITE_BELOW_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == sp_value - W'(STEP))); // R2

    AST_READ_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr == sp_value)); // R3

    AST_SP_DOWN_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (sp_value == $past(sp_value) - W'(STEP))); // R4

    AST_SP_UP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (sp_value == $past(sp_value) + W'(STEP))); // R5

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

    AST_REGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(sp_value) && $stable(pc_value))); // R9

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R10

    AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req); // R11
endmodule

bind stack_call_unit scu_chk #(.W(W), .STEP(SP_STEP)) i_scu_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sp_value (sp_value),
    .pc_value (pc_value),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/test_stack_call_unit.sv
`timescale 1ns/1ps
module test_stack_call_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = 3'd0;
    logic [15:0] op_data = 16'h0;
    logic [7:0]  op_imm = 8'h0;
    logic        busy, pop_valid, frame_valid, mem_req, mem_we, mem_ack;
    logic [15:0] sp_value, pc_value, pop_data, frame_addr, mem_addr, mem_wdata, mem_rdata;
    logic        ack_en = 1'b1;
    logic [15:0] mem [0:255];
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    stack_call_unit i_stack_call_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_data(op_data), .op_imm(op_imm), .busy(busy), .sp_value(sp_value),
        .pc_value(pc_value), .pop_valid(pop_valid), .pop_data(pop_data),
        .frame_valid(frame_valid), .frame_addr(frame_addr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Single-cycle SRAM model with optional wait states
    assign mem_ack   = mem_req & ack_en;
    assign mem_rdata = mem[mem_addr[8:1]];
    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ack) mem[mem_addr[8:1]] <= mem_wdata;
    end

    // Codes: 0 advance, 1 push, 2 pop, 3 call, 4 ret, 5 sp add, 6 sp sub, 7 frame
    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] data;
        logic [7:0]  imm;
        logic [15:0] sp;
        logic [15:0] pc;
        logic [1:0]  rsel;   // 0 none, 1 pop_data, 2 frame_addr
        logic [15:0] res;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [0:NV-1] = '{
        '{3'd0, 16'h0000, 8'h00, 16'h0000, 16'h0001, 2'd0, 16'h0000},
        '{3'd0, 16'h0000, 8'h00, 16'h0000, 16'h0002, 2'd0, 16'h0000},
        '{3'd1, 16'h1234, 8'h00, 16'hFFFE, 16'h0002, 2'd0, 16'h0000},
        '{3'd1, 16'hABCD, 8'h00, 16'hFFFC, 16'h0002, 2'd0, 16'h0000},
        '{3'd3, 16'h0100, 8'h00, 16'hFFFA, 16'h0100, 2'd0, 16'h0000},
        '{3'd0, 16'h0000, 8'h00, 16'hFFFA, 16'h0101, 2'd0, 16'h0000},
        '{3'd6, 16'h0000, 8'h06, 16'hFFF4, 16'h0101, 2'd0, 16'h0000},
        '{3'd7, 16'h0000, 8'h08, 16'hFFF4, 16'h0101, 2'd2, 16'hFFFC},
        '{3'd5, 16'h0000, 8'h06, 16'hFFFA, 16'h0101, 2'd0, 16'h0000},
        '{3'd4, 16'h0000, 8'h00, 16'hFFFC, 16'h0003, 2'd0, 16'h0000},
        '{3'd2, 16'h0000, 8'h00, 16'hFFFE, 16'h0003, 2'd1, 16'hABCD},
        '{3'd2, 16'h0000, 8'h00, 16'h0000, 16'h0003, 2'd1, 16'h1234},
        '{3'd5, 16'h0000, 8'hFF, 16'h00FF, 16'h0003, 2'd0, 16'h0000},
        '{3'd6, 16'h0000, 8'h01, 16'h00FE, 16'h0003, 2'd0, 16'h0000}
    };

    function automatic string tag_of(logic [2:0] k);
        case (k)
            3'd0: return "R8 advance";
            3'd1: return "R2 push";
            3'd2: return "R3 pop";
            3'd3: return "R4 call";
            3'd4: return "R5 return";
            3'd5, 3'd6: return "R6 sp adjust";
            default: return "R7 frame";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] k, input logic [15:0] d, input logic [7:0] i);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; op_data = d; op_imm = i;
        @(negedge clk);
        op_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pc", pc_value, 16'h0000);
        check("R1 sp", sp_value, 16'h0000);
        check("R1 busy/req/strobes", {12'h0, busy, mem_req, pop_valid, frame_valid}, 16'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_op(VECS[v].op, VECS[v].data, VECS[v].imm);
            check({tag_of(VECS[v].op), " sp"}, sp_value, VECS[v].sp);
            check({tag_of(VECS[v].op), " pc"}, pc_value, VECS[v].pc);
            if (VECS[v].rsel == 2'd1) check({tag_of(VECS[v].op), " data"}, pop_data, VECS[v].res);
            if (VECS[v].rsel == 2'd2) check({tag_of(VECS[v].op), " addr"}, frame_addr, VECS[v].res);
        end

        // Saved words in memory
        check("R4 return address stored", mem[8'hFD], 16'h0003);
        check("R2 wrap push stored at FFFE", mem[8'hFF], 16'h1234);

        // R9/R10: wait states, with an advance offered while busy
        ack_en = 1'b0;
        @(negedge clk);
        op_valid = 1'b1; op_kind = 3'd1; op_data = 16'h5555;
        @(negedge clk);
        op_kind = 3'd0;                       // advance offered during busy
        check("R9 busy during wait", {15'h0, busy}, 16'h0001);
        check("R2 write addr", mem_addr, 16'h00FC);
        check("R2 write data", mem_wdata, 16'h5555);
        @(negedge clk);
        op_valid = 1'b0;
        check("R9 sp held during wait", sp_value, 16'h00FE);
        check("R9 request held", {14'h0, mem_req, mem_we}, 16'h0003);
        ack_en = 1'b1;
        @(negedge clk);
        check("R11 completed, not busy", {15'h0, busy}, 16'h0000);
        check("R2 sp after stalled push", sp_value, 16'h00FC);
        check("R10 pc unchanged by ignored op", pc_value, 16'h0003);
        check("R11 no further request", {15'h0, mem_req}, 16'h0000);
        check("R2 stalled push stored", mem[8'h7E], 16'h5555);

        // R3 pop strobe width
        run_op(3'd2, 16'h0, 8'h0);
        check("R3 pop_valid high", {15'h0, pop_valid}, 16'h0001);
        check("R3 pop data", pop_data, 16'h5555);
        @(negedge clk);
        check("R3 pop_valid one cycle", {15'h0, pop_valid}, 16'h0000);

        // R7 frame strobe and SP untouched
        @(negedge clk);
        op_valid = 1'b1; op_kind = 3'd7; op_imm = 8'h02;
        @(negedge clk);
        op_valid = 1'b0;
        check("R7 frame_valid", {15'h0, frame_valid}, 16'h0001);
        check("R7 frame addr", frame_addr, 16'h0100);
        check("R7 sp unchanged", sp_value, 16'h00FE);
        @(negedge clk);
        check("R7 frame_valid one cycle", {15'h0, frame_valid}, 16'h0000);

        // R1 reset again
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pc after reset", pc_value, 16'h0000);
        check("R1 sp after reset", sp_value, 16'h0000);

        finish_run();
    end
endmodule